// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block keeps recently used virtual-to-physical page mappings so that a memory access which finds its page here needs no page table walk. A lookup presents a 32-bit virtual address and, in the same cycle, gets back a hit flag, the physical address and the permission flags of the mapping. On a miss the block raises a walk request. The walker outside then writes the result back through the fill port as a virtual page number, a physical page number and permission flags. Pages are 4 KiB, so the low 12 address bits pass through untranslated.

Two invalidation commands keep the cache consistent with memory. The single-page command drops the one mapping whose virtual page number matches, for use after a page table entry is edited. The flush command drops every mapping, for use when a new page-directory base is loaded. When a fill has no free slot, the least recently used mapping is replaced. Both a lookup hit and a fill count as a use. The array is 64 entries by default, and every width and the depth are parameters.

Top module: `tlb_xlate_cache`

## Requirements
- R1: On a hit, `lk_hit` is 1 and `lk_walk_req` is 0. `lk_paddr` is the stored physical page number in bits [31:12] joined with `lk_vaddr[11:0]`. `lk_perm` is the stored flag value. On a miss, `lk_paddr` and `lk_perm` are zero.
- R2: When `lk_valid` is 1 and no valid entry matches `lk_vaddr[31:12]`, `lk_hit` is 0 and `lk_walk_req` is 1. When `lk_valid` is 0, both outputs are 0.
- R3: A fill accepted at a clock edge can be looked up from the next cycle on, with the filled page numbers and flags.
- R4: A fill whose virtual page number already has a valid entry overwrites that entry. It creates no second copy and evicts no other entry.
- R5: A fill with no matching entry goes into an invalid slot whenever one exists. No valid mapping is evicted while a slot is free.
- R6: When every slot is valid, a new fill replaces the entry whose last use is the oldest. A lookup hit and an accepted fill each count as a use of their entry.
- R7: A single-page invalidate makes the entry with the given virtual page number miss from the next cycle on. All other entries are left valid.
- R8: A flush makes every entry miss from the next cycle on.
- R9: A lookup in the same cycle as a flush, or as a single-page invalidate of the same virtual page number, reports a miss.
- R10: A fill in the same cycle as a flush, or as a single-page invalidate of its own virtual page number, is discarded.
- R11: After reset, every entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VA_W (32) | Virtual address to translate |
| lk_hit | output | 1 | Lookup found a valid mapping |
| lk_walk_req | output | 1 | Lookup missed; a table walk is needed |
| lk_paddr | output | PA_W (32) | Translated physical address |
| lk_perm | output | PERM_W (4) | Permission flags of the hit mapping |
| fill_valid | input | 1 | Write a mapping at this clock edge |
| fill_vpn | input | VA_W-12 (20) | Virtual page number to write |
| fill_ppn | input | PA_W-12 (20) | Physical page number to write |
| fill_perm | input | PERM_W (4) | Permission flags to write |
| inv_page_valid | input | 1 | Invalidate one mapping |
| inv_page_vpn | input | VA_W-12 (20) | Virtual page number to invalidate |
| flush_all | input | 1 | Invalidate all mappings |

## Verification
The bench builds the block with four entries and keeps the default address widths. With four slots, a pool of six virtual pages is enough to force evictions again and again, so the replacement order, free-slot reuse and overwrite of an existing page can all be observed from lookup results. Directed cycles combine lookups and fills with same-cycle invalidates and flushes. A long pseudo-random sequence of lookups, fills, page invalidates and rare flushes is then compared against a reference model in the bench that orders entries by time of last use.

// File: rtl/tlb_xlate_pkg.sv
package tlb_xlate_pkg;

   // Width of an index into an array of n slots (at least one bit).
   function automatic int idx_bits(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

   // Source of a recency update in a given cycle.
   typedef enum logic [1:0] {
      TOUCH_NONE   = 2'd0,
      TOUCH_LOOKUP = 2'd1,
      TOUCH_FILL   = 2'd2
   } touch_src_e;

endpackage

// File: rtl/tlb_tag_match.sv
module tlb_tag_match #(
   parameter int ENTRIES = 64,
   parameter int KEY_W   = 20
) (
   input  logic [ENTRIES-1:0][KEY_W-1:0] tags,
   input  logic [ENTRIES-1:0]            live,
   input  logic [KEY_W-1:0]              key,
   output logic [ENTRIES-1:0]            match,
   output logic                          any
);

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match[g] = live[g] && (tags[g] == key);
   end

   assign any = |match;

endmodule

// File: rtl/tlb_lru_ages.sv
module tlb_lru_ages #(
   parameter int ENTRIES = 64,
   parameter int IDX_W   = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             touch_en,
   input  logic [IDX_W-1:0] touch_idx,
   output logic [IDX_W-1:0] oldest_idx
);

   localparam logic [IDX_W-1:0] MAX_RANK = IDX_W'(ENTRIES - 1);

   // Each slot holds a rank: 0 = most recent, ENTRIES-1 = oldest.
   // The ranks always form a permutation of 0..ENTRIES-1.
   logic [ENTRIES-1:0][IDX_W-1:0] rank;
   logic [IDX_W-1:0]              touched_rank;

   assign touched_rank = rank[touch_idx];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_rank
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rank[g] <= IDX_W'(g);
         end else if (touch_en) begin
            if (touch_idx == IDX_W'(g)) begin
               rank[g] <= '0;
            end else if (rank[g] < touched_rank) begin
               rank[g] <= rank[g] + 1'b1;
            end
         end
      end
   end

   always_comb begin
      oldest_idx = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (rank[i] == MAX_RANK) oldest_idx = IDX_W'(i);
      end
   end

endmodule

// File: rtl/tlb_victim_pick.sv
module tlb_victim_pick #(
   parameter int ENTRIES = 64,
   parameter int IDX_W   = 6
) (
   input  logic [ENTRIES-1:0] live,
   input  logic [ENTRIES-1:0] fill_match,
   input  logic [IDX_W-1:0]   oldest_idx,
   output logic [IDX_W-1:0]   slot
);

   logic             free_found;
   logic [IDX_W-1:0] free_idx;
   logic [IDX_W-1:0] match_idx;

   // Lowest-numbered free slot and index of the matching slot.
   always_comb begin
      free_found = 1'b0;
      free_idx   = '0;
      match_idx  = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!live[i]) begin
            free_found = 1'b1;
            free_idx   = IDX_W'(i);
         end
         if (fill_match[i]) match_idx = IDX_W'(i);
      end
   end

   // Priority: same page already present, then a free slot, then the oldest.
   always_comb begin
      if (|fill_match)     slot = match_idx;
      else if (free_found) slot = free_idx;
      else                 slot = oldest_idx;
   end

endmodule

// File: rtl/tlb_xlate_cache.sv
module tlb_xlate_cache #(
   parameter int  VA_W    = 32,
   parameter int  PA_W    = 32,
   parameter int  OFF_W   = 12,
   parameter int  ENTRIES = 64,
   parameter int  PERM_W  = 4,
   localparam int VPN_W   = VA_W - OFF_W,
   localparam int PPN_W   = PA_W - OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [VA_W-1:0]   lk_vaddr,
   output logic              lk_hit,
   output logic              lk_walk_req,
   output logic [PA_W-1:0]   lk_paddr,
   output logic [PERM_W-1:0] lk_perm,
   input  logic              fill_valid,
   input  logic [VPN_W-1:0]  fill_vpn,
   input  logic [PPN_W-1:0]  fill_ppn,
   input  logic [PERM_W-1:0] fill_perm,
   input  logic              inv_page_valid,
   input  logic [VPN_W-1:0]  inv_page_vpn,
   input  logic              flush_all
);
   import tlb_xlate_pkg::*;

   localparam int IDX_W = idx_bits(ENTRIES);

   // Elaboration-time parameter checks
   if (ENTRIES < 2) begin : g_bad_entries
      $error("tlb_xlate_cache: ENTRIES must be at least 2");
   end
   if (OFF_W < 1 || OFF_W >= VA_W || OFF_W >= PA_W) begin : g_bad_offset
      $error("tlb_xlate_cache: OFF_W must be smaller than both address widths");
   end
   if (PERM_W < 1) begin : g_bad_perm
      $error("tlb_xlate_cache: PERM_W must be at least 1");
   end

   // Entry storage
   logic [ENTRIES-1:0]              valid_q;
   logic [ENTRIES-1:0][VPN_W-1:0]   vpn_q;
   logic [ENTRIES-1:0][PPN_W-1:0]   ppn_q;
   logic [ENTRIES-1:0][PERM_W-1:0]  perm_q;

   // Three compare ports over the same tags
   logic [VPN_W-1:0]   lk_vpn;
   logic [ENTRIES-1:0] lk_match, fill_match, inv_match;
   logic               lk_any, fill_any, inv_any;

   assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];

   tlb_tag_match #(.ENTRIES(ENTRIES), .KEY_W(VPN_W)) i_match_lk (
      .tags(vpn_q), .live(valid_q), .key(lk_vpn),
      .match(lk_match), .any(lk_any));

   tlb_tag_match #(.ENTRIES(ENTRIES), .KEY_W(VPN_W)) i_match_fill (
      .tags(vpn_q), .live(valid_q), .key(fill_vpn),
      .match(fill_match), .any(fill_any));

   tlb_tag_match #(.ENTRIES(ENTRIES), .KEY_W(VPN_W)) i_match_inv (
      .tags(vpn_q), .live(valid_q), .key(inv_page_vpn),
      .match(inv_match), .any(inv_any));

   // Same-cycle invalidation wins over lookup and fill
   logic lk_killed, fill_ok;
   assign lk_killed = flush_all || (inv_page_valid && (inv_page_vpn == lk_vpn));
   assign fill_ok   = fill_valid && !flush_all &&
                      !(inv_page_valid && (inv_page_vpn == fill_vpn));

   assign lk_hit      = lk_valid && lk_any && !lk_killed;
   assign lk_walk_req = lk_valid && !lk_hit;

   // Read mux: tags are unique, so an OR over masked slots suffices
   logic [PPN_W-1:0]  hit_ppn;
   logic [PERM_W-1:0] hit_perm;
   logic [IDX_W-1:0]  hit_idx;

   always_comb begin
      hit_ppn  = '0;
      hit_perm = '0;
      hit_idx  = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (lk_match[i]) begin
            hit_ppn  = hit_ppn | ppn_q[i];
            hit_perm = hit_perm | perm_q[i];
            hit_idx  = hit_idx | IDX_W'(i);
         end
      end
   end

   assign lk_paddr = lk_hit ? {hit_ppn, lk_vaddr[OFF_W-1:0]} : '0;
   assign lk_perm  = lk_hit ? hit_perm : '0;

   // Recency tracking and slot choice
   touch_src_e       touch_src;
   logic [IDX_W-1:0] oldest_idx;
   logic [IDX_W-1:0] fill_slot;
   logic [IDX_W-1:0] touch_idx;

   always_comb begin
      if (fill_ok)     touch_src = TOUCH_FILL;
      else if (lk_hit) touch_src = TOUCH_LOOKUP;
      else             touch_src = TOUCH_NONE;
   end

   assign touch_idx = (touch_src == TOUCH_FILL) ? fill_slot : hit_idx;

   tlb_lru_ages #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) i_ages (
      .clk(clk), .rst_n(rst_n),
      .touch_en(touch_src != TOUCH_NONE),
      .touch_idx(touch_idx),
      .oldest_idx(oldest_idx));

   tlb_victim_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) i_victim (
      .live(valid_q), .fill_match(fill_match),
      .oldest_idx(oldest_idx), .slot(fill_slot));

   // Valid bits: flush, then page invalidate, then fill
   logic [ENTRIES-1:0] valid_d;

   always_comb begin
      valid_d = valid_q;
      if (flush_all) begin
         valid_d = '0;
      end else begin
         if (inv_page_valid && inv_any) valid_d = valid_d & ~inv_match;
         if (fill_ok) valid_d[fill_slot] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q <= '0;
      else        valid_q <= valid_d;
   end

   // Payload storage needs no reset: it is only read through valid bits
   for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (fill_ok && (fill_slot == IDX_W'(g))) begin
            vpn_q[g]  <= fill_vpn;
            ppn_q[g]  <= fill_ppn;
            perm_q[g] <= fill_perm;
         end
      end
   end

endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
   parameter int VA_W   = 32,
   parameter int PA_W   = 32,
   parameter int OFF_W  = 12,
   parameter int PERM_W = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    lk_valid,
   input logic [VA_W-1:0]         lk_vaddr,
   input logic                    lk_hit,
   input logic                    lk_walk_req,
   input logic [PA_W-1:0]         lk_paddr,
   input logic [PERM_W-1:0]       lk_perm,
   input logic                    fill_valid,
   input logic [VA_W-OFF_W-1:0]   fill_vpn,
   input logic [PA_W-OFF_W-1:0]   fill_ppn,
   input logic [PERM_W-1:0]       fill_perm,
   input logic                    inv_page_valid,
   input logic [VA_W-OFF_W-1:0]   inv_page_vpn,
   input logic                    flush_all
);

   logic fill_taken;
   assign fill_taken = fill_valid && !flush_all &&
                       !(inv_page_valid && (inv_page_vpn == fill_vpn));

   AST_HIT_KEEPS_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0])); // R1

   AST_HIT_NO_WALK: assert property (@(posedge clk) disable iff (!rst_n)
      !(lk_hit && lk_walk_req)); // R1

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |-> (!lk_hit && !lk_walk_req)); // R2

   AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      fill_taken |=> ((lk_valid && lk_vaddr[VA_W-1:OFF_W] == $past(fill_vpn) &&
                      !flush_all &&
                      !(inv_page_valid && inv_page_vpn == lk_vaddr[VA_W-1:OFF_W]))
                      -> (lk_hit && lk_paddr[PA_W-1:OFF_W] == $past(fill_ppn) &&
                          lk_perm == $past(fill_perm)))); // R3

   AST_PAGE_GONE: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_page_valid && !(fill_valid && fill_vpn == inv_page_vpn)) |=>
         !(lk_hit && lk_vaddr[VA_W-1:OFF_W] == $past(inv_page_vpn))); // R7

   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush_all |=> !lk_hit); // R8

   AST_KILL_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_all || (inv_page_valid && inv_page_vpn == lk_vaddr[VA_W-1:OFF_W]))
         |-> !lk_hit); // R9

endmodule

bind tlb_xlate_cache tlb_xlate_chk #(
   .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .PERM_W(PERM_W)
) i_tlb_xlate_chk (.*);

// File: tb/test_tlb_xlate_cache.sv
module test_tlb_xlate_cache;

   localparam int CLK_PERIOD = 10;
   localparam int N_ENT      = 4;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_vaddr = '0;
   logic        lk_hit, lk_walk_req;
   logic [31:0] lk_paddr;
   logic [3:0]  lk_perm;
   logic        fill_valid = 1'b0;
   logic [19:0] fill_vpn = '0;
   logic [19:0] fill_ppn = '0;
   logic [3:0]  fill_perm = '0;
   logic        inv_page_valid = 1'b0;
   logic [19:0] inv_page_vpn = '0;
   logic        flush_all = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tlb_xlate_cache #(.ENTRIES(N_ENT)) i_tlb_xlate_cache (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
      .lk_hit(lk_hit), .lk_walk_req(lk_walk_req),
      .lk_paddr(lk_paddr), .lk_perm(lk_perm),
      .fill_valid(fill_valid), .fill_vpn(fill_vpn),
      .fill_ppn(fill_ppn), .fill_perm(fill_perm),
      .inv_page_valid(inv_page_valid), .inv_page_vpn(inv_page_vpn),
      .flush_all(flush_all));

   int  n_chk = 0;
   int  n_err = 0;
   bit  done  = 1'b0;

   // Reference model: slots ordered by time of last use
   bit          m_val  [N_ENT];
   logic [19:0] m_vpn  [N_ENT];
   logic [19:0] m_ppn  [N_ENT];
   logic [3:0]  m_perm [N_ENT];
   int          m_use  [N_ENT];
   int          tick = 0;

   // Observed and model-expected lookup results of the last cycle
   bit          o_hit, o_walk, e_hit;
   logic [31:0] o_pa, e_pa;
   logic [3:0]  o_perm, e_perm;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int m_find(input logic [19:0] vpn);
      for (int i = 0; i < N_ENT; i++) if (m_val[i] && m_vpn[i] == vpn) return i;
      return -1;
   endfunction

   function automatic int m_slot(input logic [19:0] vpn);
      int s, best;
      s = m_find(vpn);
      if (s >= 0) return s;
      for (int i = 0; i < N_ENT; i++) if (!m_val[i]) return i;
      best = 0;
      for (int i = 1; i < N_ENT; i++) if (m_use[i] < m_use[best]) best = i;
      return best;
   endfunction

   // One clock cycle with any mix of operations
   task automatic cyc(input bit l, input logic [31:0] va,
                      input bit iv, input logic [19:0] ivpn,
                      input bit fl,
                      input bit f, input logic [19:0] fvpn,
                      input logic [19:0] fppn, input logic [3:0] fperm);
      int  hs, fs;
      bit  fok;
      @(negedge clk);
      lk_valid = l;  lk_vaddr = va;
      inv_page_valid = iv; inv_page_vpn = ivpn;
      flush_all = fl;
      fill_valid = f; fill_vpn = fvpn; fill_ppn = fppn; fill_perm = fperm;
      #1;
      o_hit = lk_hit; o_walk = lk_walk_req; o_pa = lk_paddr; o_perm = lk_perm;
      hs = m_find(va[31:12]);
      e_hit = l && (hs >= 0) && !fl && !(iv && ivpn == va[31:12]);
      e_pa   = e_hit ? {m_ppn[hs], va[11:0]} : 32'h0;
      e_perm = e_hit ? m_perm[hs] : 4'h0;
      fok = f && !fl && !(iv && ivpn == fvpn);
      fs  = m_slot(fvpn);
      @(posedge clk);
      if (fl) begin
         for (int i = 0; i < N_ENT; i++) m_val[i] = 1'b0;
      end else if (iv) begin
         for (int i = 0; i < N_ENT; i++) if (m_val[i] && m_vpn[i] == ivpn) m_val[i] = 1'b0;
      end
      if (fok) begin
         m_val[fs] = 1'b1; m_vpn[fs] = fvpn; m_ppn[fs] = fppn; m_perm[fs] = fperm;
         tick++; m_use[fs] = tick;
      end else if (e_hit) begin
         tick++; m_use[hs] = tick;
      end
      #1;
      lk_valid = 1'b0; inv_page_valid = 1'b0; flush_all = 1'b0; fill_valid = 1'b0;
   endtask

   task automatic do_fill(input logic [19:0] vpn, input logic [19:0] ppn, input logic [3:0] pm);
      cyc(0, '0, 0, '0, 0, 1, vpn, ppn, pm);
   endtask

   task automatic probe(input logic [31:0] va, input bit xh, input logic [31:0] xpa, input string req);
      cyc(1, va, 0, '0, 0, 0, '0, '0, '0);
      check(o_hit == xh, req, "hit", 64'(o_hit), 64'(xh));
      check(o_walk == !xh, req, "walk_req", 64'(o_walk), 64'(!xh));
      if (xh) check(o_pa == xpa, req, "paddr", 64'(o_pa), 64'(xpa));
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog run did not complete actual=%0d expected=0", WATCHDOG);
      finish_run();
   end

   initial begin
      logic [15:0] lf;
      logic [19:0] pv;
      for (int i = 0; i < N_ENT; i++) begin m_val[i] = 0; m_use[i] = 0; m_vpn[i] = '0; m_ppn[i] = '0; m_perm[i] = '0; end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R11 / R2: empty after reset, walk requested on miss, quiet when idle
      probe(32'h0804_8338, 0, 0, "R11");
      cyc(0, 32'h0804_8338, 0, '0, 0, 0, '0, '0, '0);
      check(!o_hit && !o_walk, "R2", "idle hit|walk", {62'b0, o_hit, o_walk}, 0);

      // R1 / R3: fill then hit with offset passthrough and flags
      do_fill(20'h08048, 20'h00010, 4'h5);
      probe(32'h0804_8338, 1, 32'h0001_0338, "R3");
      check(o_perm == 4'h5, "R1", "perm", 64'(o_perm), 64'h5);

      // R4: fill the array, then overwrite an existing page
      do_fill(20'h44332, 20'h33885, 4'h3);
      do_fill(20'h08049, 20'h00011, 4'h1);
      do_fill(20'h0804A, 20'h00014, 4'h1);
      do_fill(20'h08048, 20'h00050, 4'h2);
      probe(32'h0804_8fff, 1, 32'h0005_0fff, "R4");
      check(o_perm == 4'h2, "R4", "perm", 64'(o_perm), 64'h2);
      probe(32'h4433_25af, 1, 32'h3388_55af, "R4");
      probe(32'h0804_9000, 1, 32'h0001_1000, "R4");
      probe(32'h0804_A010, 1, 32'h0001_4010, "R4");

      // R7: single page invalidate
      cyc(0, '0, 1, 20'h08049, 0, 0, '0, '0, '0);
      probe(32'h0804_9000, 0, 0, "R7");
      probe(32'h0804_A020, 1, 32'h0001_4020, "R7");

      // R5: free slot reused, no live mapping evicted
      do_fill(20'hBFFDF, 20'h00012, 4'h7);
      probe(32'hBFFD_F004, 1, 32'h0001_2004, "R5");
      probe(32'h0804_8001, 1, 32'h0005_0001, "R5");
      probe(32'h4433_2000, 1, 32'h3388_5000, "R5");
      probe(32'h0804_A000, 1, 32'h0001_4000, "R5");

      // R9: same-cycle page invalidate / flush beats lookup
      cyc(1, 32'h0804_A123, 1, 20'h0804A, 0, 0, '0, '0, '0);
      check(!o_hit && o_walk, "R9", "hit with same-page invalidate", 64'(o_hit), 0);
      cyc(1, 32'h4433_2000, 1, 20'h08048, 0, 0, '0, '0, '0);
      check(o_hit && o_pa == 32'h3388_5000, "R7", "other page during invalidate", 64'(o_pa), 64'h3388_5000);
      probe(32'h0804_8000, 0, 0, "R7");

      // R10: fill with same-page invalidate is dropped
      cyc(0, '0, 1, 20'h12345, 0, 1, 20'h12345, 20'h00777, 4'h1);
      probe(32'h1234_5678, 0, 0, "R10");

      // R9 / R8: lookup during flush misses, everything gone afterwards
      cyc(1, 32'hBFFD_F000, 0, '0, 1, 0, '0, '0, '0);
      check(!o_hit, "R9", "hit during flush", 64'(o_hit), 0);
      probe(32'hBFFD_F000, 0, 0, "R8");
      probe(32'h4433_2000, 0, 0, "R8");

      // R10: fill during flush is dropped
      cyc(0, '0, 0, '0, 1, 1, 20'h55555, 20'h00100, 4'h1);
      probe(32'h5555_5000, 0, 0, "R10");

      // R6: least recently used order with lookup refresh
      for (int i = 0; i < 4; i++) do_fill(20'h00100 + 20'(i), 20'h00200 + 20'(i), 4'h1);
      probe(32'h0010_0000, 1, 32'h0020_0000, "R6");
      do_fill(20'h00104, 20'h00204, 4'h1);
      probe(32'h0010_1000, 0, 0, "R6");
      probe(32'h0010_0000, 1, 32'h0020_0000, "R6");
      probe(32'h0010_2000, 1, 32'h0020_2000, "R6");
      probe(32'h0010_3000, 1, 32'h0020_3000, "R6");
      probe(32'h0010_4000, 1, 32'h0020_4000, "R6");
      do_fill(20'h00105, 20'h00205, 4'h1);
      probe(32'h0010_0000, 0, 0, "R6");
      probe(32'h0010_2000, 1, 32'h0020_2000, "R6");

      // Sweep against the reference model (R3 R6 R7 R8)
      lf = 16'hACE1;
      for (int s = 0; s < 600; s++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         pv = 20'h70000 + 20'(lf[7:4] % 6);
         if (lf[3:0] < 8) begin
            cyc(1, {pv, lf[15:8], lf[3:0]}, 0, '0, 0, 0, '0, '0, '0);
            check(o_hit == e_hit, "R6", "sweep hit", 64'(o_hit), 64'(e_hit));
            check(o_walk == !e_hit, "R2", "sweep walk", 64'(o_walk), 64'(!e_hit));
            check(o_pa == e_pa && o_perm == e_perm, "R3", "sweep paddr",
                  64'(o_pa), 64'(e_pa));
         end else if (lf[3:0] < 12) begin
            do_fill(pv, {lf, lf[11:8]}, lf[15:12]);
         end else if (lf[3:0] < 15) begin
            cyc(0, '0, 1, pv, 0, 0, '0, '0, '0);
         end else if (lf[9:8] == 2'b00) begin
            cyc(0, '0, 0, '0, 1, 0, '0, '0, '0);
         end
      end

      finish_run();
   end

endmodule